// File: doc/BRIEF.md
# Program Counter Next-Address Generator

This block holds the program counter of a byte-oriented 8-bit controller with a 16-bit code space and works out the address it moves to next. Each cycle the decoder presents a transfer class, the instruction length, up to two operand bytes, the page field taken from the opcode, a branch-condition bit, the accumulator and the 16-bit data pointer. From these the block forms the next PC. When `step` is high the PC register takes that value at the clock edge.

The block also drives two side results. `ret_addr` is the address of the instruction after the current one, which the stack logic pushes for calls. `table_addr` is the PC-relative code-read address used for table lookups. Fetch, decode and the stack are outside this block.

Top module: `pc_next_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc` becomes 0x0000.
- R2: With `step` low, `pc` keeps its value across an edge. With `step` high, `pc` takes the `pc_next` value that was present before the edge.
- R3: For class SEQ (`kind` = 0, and also the unused codes 6 and 7), `pc_next` = `pc` + `ilen`, where `ilen` is 1, 2 or 3. The sum wraps modulo 65536.
- R4: For class ABS (`kind` = 1), `pc_next` takes bits 15:11 from (`pc` + `ilen`), bits 10:8 from `page` (opcode bits 7:5), and bits 7:0 from `op1`.
- R5: For class LONG (`kind` = 2), `pc_next` = {`op1`, `op2`}, with `op1` as the high byte.
- R6: For class REL (`kind` = 3), `pc_next` = (`pc` + `ilen`) + the sign-extended offset, wrapping modulo 65536. The offset is the last operand byte: `op1` when `ilen` = 2 and `op2` when `ilen` = 3.
- R7: For class BRC (`kind` = 4), `pc_next` is the R6 target when `cond` = 1 and `pc` + `ilen` when `cond` = 0.
- R8: For class IDX (`kind` = 5), `pc_next` = `dptr` + `acc`, wrapping modulo 65536.
- R9: `ret_addr` = `pc` + `ilen` for every class. For a 3-byte long call this is `pc` + 3.
- R10: `table_addr` = `pc` + 1 + `acc`, wrapping modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | Load `pc_next` into the PC at this edge |
| kind | input | 3 | Transfer class (0 SEQ, 1 ABS, 2 LONG, 3 REL, 4 BRC, 5 IDX) |
| ilen | input | 2 | Instruction length in bytes (1 to 3) |
| page | input | 3 | Page field, opcode bits 7:5 |
| op1 | input | 8 | First operand byte |
| op2 | input | 8 | Second operand byte |
| cond | input | 1 | Branch condition for BRC |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| pc | output | 16 | Current program counter |
| pc_next | output | 16 | Next program counter |
| ret_addr | output | 16 | Address of the following instruction |
| table_addr | output | 16 | PC-relative code-read address |

## Verification
`pc_next`, `ret_addr` and `table_addr` are combinational. They are due in the same cycle their inputs change. The bench drives those inputs on a falling edge and samples the outputs a short time later, before the next rising edge.

`pc` is registered, so a `step` or a reset takes effect one rising edge later. The bench therefore checks `pc` at the falling edge that follows that rising edge. To place the PC at a chosen start address, the bench performs a LONG load and verifies the result before it relies on it.

// File: rtl/pcgen_pkg.sv
// Shared types for the PC next-address generator.
package pcgen_pkg;
    // Transfer class presented by the decoder.
    typedef enum logic [2:0] {
        XF_SEQ  = 3'd0,
        XF_ABS  = 3'd1,
        XF_LONG = 3'd2,
        XF_REL  = 3'd3,
        XF_BRC  = 3'd4,
        XF_IDX  = 3'd5
    } xfer_e;
endpackage

// File: rtl/pc_linear_calc.sv
// Linear address arithmetic. Produces the fall-through address
// (PC + length) and the PC-relative table-read address (PC + 1 + acc).
// Assumes ilen is 1..3; every sum wraps and raises no flag.
module pc_linear_calc #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] pc,
    input  logic [1:0]    ilen,
    input  logic [DW-1:0] acc,
    output logic [AW-1:0] fall,
    output logic [AW-1:0] tbl
);
    localparam int PADW = AW - DW;

    // Fall-through and table address sums.
    always_comb begin
        fall = pc + {{(AW-2){1'b0}}, ilen};
        tbl  = pc + {{(AW-1){1'b0}}, 1'b1} + {{PADW{1'b0}}, acc};
    end
endmodule

// File: rtl/pc_target_calc.sv
// Forms the four transfer targets: the absolute page target, the long
// target, the relative target and the indexed target. The relative offset
// is the last operand byte. Assumes AW > DW + PGW.
module pc_target_calc #(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int PGW = 3
) (
    input  logic [AW-1:0]  fall,
    input  logic [1:0]     ilen,
    input  logic [PGW-1:0] page,
    input  logic [DW-1:0]  op1,
    input  logic [DW-1:0]  op2,
    input  logic [DW-1:0]  acc,
    input  logic [AW-1:0]  dptr,
    output logic [AW-1:0]  abs_tgt,
    output logic [AW-1:0]  long_tgt,
    output logic [AW-1:0]  rel_tgt,
    output logic [AW-1:0]  idx_tgt
);
    localparam int KEEP = AW - DW - PGW;
    localparam int PADW = AW - DW;

    logic [DW-1:0] offset;

    // Pick the offset byte: the byte after the opcode for 2-byte forms,
    // the third byte for 3-byte forms.
    always_comb offset = (ilen == 2'd3) ? op2 : op1;

    // Target arithmetic for each transfer form.
    always_comb begin
        abs_tgt  = {fall[AW-1 -: KEEP], page, op1};
        long_tgt = {{(AW-2*DW){1'b0}}, op1, op2};
        rel_tgt  = fall + {{PADW{offset[DW-1]}}, offset};
        idx_tgt  = dptr + {{PADW{1'b0}}, acc};
    end
endmodule

// File: rtl/pc_next_sel.sv
// Chooses the next PC from the class and the branch condition.
// Unused class codes behave as sequential.
module pc_next_sel
    import pcgen_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [2:0]    kind,
    input  logic          cond,
    input  logic [AW-1:0] fall,
    input  logic [AW-1:0] abs_tgt,
    input  logic [AW-1:0] long_tgt,
    input  logic [AW-1:0] rel_tgt,
    input  logic [AW-1:0] idx_tgt,
    output logic [AW-1:0] nxt
);
    // Class decode and selection.
    always_comb begin
        unique case (kind)
            XF_ABS:  nxt = abs_tgt;
            XF_LONG: nxt = long_tgt;
            XF_REL:  nxt = rel_tgt;
            XF_BRC:  nxt = cond ? rel_tgt : fall;
            XF_IDX:  nxt = idx_tgt;
            default: nxt = fall;
        endcase
    end
endmodule

// File: rtl/pc_next_gen.sv
// Program counter register and next-address generator. Holds the PC,
// loads pc_next when step is high and clears the PC on a synchronous
// active-low reset. Assumes the decoder supplies a legal ilen (1..3).
module pc_next_gen
    import pcgen_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int PGW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic [2:0]     kind,
    input  logic [1:0]     ilen,
    input  logic [PGW-1:0] page,
    input  logic [DW-1:0]  op1,
    input  logic [DW-1:0]  op2,
    input  logic           cond,
    input  logic [DW-1:0]  acc,
    input  logic [AW-1:0]  dptr,
    output logic [AW-1:0]  pc,
    output logic [AW-1:0]  pc_next,
    output logic [AW-1:0]  ret_addr,
    output logic [AW-1:0]  table_addr
);
    logic [AW-1:0] fall, abs_tgt, long_tgt, rel_tgt, idx_tgt;

    pc_linear_calc #(.AW(AW), .DW(DW)) u_lin (
        .pc(pc), .ilen(ilen), .acc(acc), .fall(fall), .tbl(table_addr)
    );

    pc_target_calc #(.AW(AW), .DW(DW), .PGW(PGW)) u_tgt (
        .fall(fall), .ilen(ilen), .page(page), .op1(op1), .op2(op2),
        .acc(acc), .dptr(dptr), .abs_tgt(abs_tgt), .long_tgt(long_tgt),
        .rel_tgt(rel_tgt), .idx_tgt(idx_tgt)
    );

    pc_next_sel #(.AW(AW)) u_sel (
        .kind(kind), .cond(cond), .fall(fall), .abs_tgt(abs_tgt),
        .long_tgt(long_tgt), .rel_tgt(rel_tgt), .idx_tgt(idx_tgt),
        .nxt(pc_next)
    );

    assign ret_addr = fall;

    // PC register with synchronous reset and step-gated load.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= '0;
        else if (step) pc <= pc_next;
    end

    // R1: reset clears the PC at the next edge
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> pc == '0);

    // R2: no step, no movement
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc));

    // R2: step loads the computed next address
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> pc == $past(pc_next));

    // R3: sequential class follows the return address
    p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == XF_SEQ) |-> pc_next == ret_addr);

    // R5: long class loads both operand bytes
    p_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == XF_LONG) |-> pc_next == {op1, op2});

    // R7: a branch that is not taken falls through
    p_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == XF_BRC && !cond) |-> pc_next == ret_addr);
endmodule

// File: tb/pc_next_gen_test.sv
module pc_next_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [2:0]  kind = 3'd0;
    logic [1:0]  ilen = 2'd1;
    logic [2:0]  page = 3'd0;
    logic [7:0]  op1 = 8'd0, op2 = 8'd0, acc = 8'd0;
    logic        cond = 1'b0;
    logic [15:0] dptr = 16'd0;
    logic [15:0] pc, pc_next, ret_addr, table_addr;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pc_next_gen uut (
        .clk(clk), .rst_n(rst_n), .step(step), .kind(kind), .ilen(ilen),
        .page(page), .op1(op1), .op2(op2), .cond(cond), .acc(acc),
        .dptr(dptr), .pc(pc), .pc_next(pc_next), .ret_addr(ret_addr),
        .table_addr(table_addr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive combinational inputs on a falling edge and let them settle.
    task automatic setc(input logic [2:0] k, input logic [1:0] l, input logic [7:0] a,
                        input logic [7:0] b, input logic c);
        @(negedge clk);
        kind = k; ilen = l; op1 = a; op2 = b; cond = c;
        #1;
    endtask

    // Place the PC using a LONG load; checked under R5.
    task automatic load_pc(input logic [15:0] a);
        setc(3'd2, 2'd3, a[15:8], a[7:0], 1'b0);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        check("R5 long load", pc, a);
    endtask

    task automatic t_reset;
        check("R1 reset pc", pc, 16'h0000);
        load_pc(16'h4321);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 mid-run reset", pc, 16'h0000);
    endtask

    task automatic t_step;
        load_pc(16'h1234);
        setc(3'd0, 2'd2, 8'h00, 8'h00, 1'b0);
        @(negedge clk);
        check("R2 hold without step", pc, 16'h1234);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        check("R2 step loads", pc, 16'h1236);
    endtask

    task automatic t_seq;
        load_pc(16'h1234);
        setc(3'd0, 2'd1, 8'h00, 8'h00, 1'b0); check("R3 len1", pc_next, 16'h1235);
        setc(3'd0, 2'd3, 8'h00, 8'h00, 1'b0); check("R3 len3", pc_next, 16'h1237);
        setc(3'd7, 2'd2, 8'h00, 8'h00, 1'b0); check("R3 unused code", pc_next, 16'h1236);
        load_pc(16'hFFFF);
        setc(3'd0, 2'd2, 8'h00, 8'h00, 1'b0); check("R3 wrap", pc_next, 16'h0001);
    endtask

    task automatic t_abs;
        load_pc(16'h07FE);
        page = 3'd7;
        setc(3'd1, 2'd2, 8'h5A, 8'h00, 1'b0); check("R4 block from next instr", pc_next, 16'h0F5A);
        load_pc(16'h1234);
        page = 3'd1;
        setc(3'd1, 2'd2, 8'h33, 8'h00, 1'b0); check("R4 page 1", pc_next, 16'h1133);
        check("R9 ret after abs call", ret_addr, 16'h1236);
    endtask

    task automatic t_long;
        load_pc(16'h1000);
        setc(3'd2, 2'd3, 8'hAB, 8'hCD, 1'b0);
        check("R5 long target", pc_next, 16'hABCD);
        check("R9 long call ret", ret_addr, 16'h1003);
    endtask

    task automatic t_rel;
        load_pc(16'h0100);
        setc(3'd3, 2'd2, 8'hFE, 8'h00, 1'b0); check("R6 negative", pc_next, 16'h0100);
        setc(3'd3, 2'd3, 8'h00, 8'h7F, 1'b0); check("R6 third byte", pc_next, 16'h0182);
        setc(3'd3, 2'd2, 8'h80, 8'h00, 1'b0); check("R6 -128", pc_next, 16'h0082);
        load_pc(16'hFFF0);
        setc(3'd3, 2'd2, 8'h20, 8'h00, 1'b0); check("R6 wrap", pc_next, 16'h0012);
    endtask

    task automatic t_cond;
        load_pc(16'h2000);
        setc(3'd4, 2'd3, 8'h55, 8'h10, 1'b1); check("R7 taken", pc_next, 16'h2013);
        setc(3'd4, 2'd3, 8'h55, 8'h10, 1'b0); check("R7 not taken", pc_next, 16'h2003);
        setc(3'd4, 2'd2, 8'hF0, 8'h00, 1'b1); check("R7 taken back", pc_next, 16'h1FF2);
    endtask

    task automatic t_idx;
        @(negedge clk); dptr = 16'hFFF0; acc = 8'h20;
        setc(3'd5, 2'd1, 8'h00, 8'h00, 1'b0); check("R8 wrap", pc_next, 16'h0010);
        @(negedge clk); dptr = 16'h1000; acc = 8'hFF; #1;
        check("R8 index", pc_next, 16'h10FF);
    endtask

    task automatic t_table;
        load_pc(16'h2000);
        @(negedge clk); acc = 8'h10; #1;
        check("R10 table", table_addr, 16'h2011);
        load_pc(16'hFFFF);
        @(negedge clk); acc = 8'h00; #1;
        check("R10 wrap", table_addr, 16'h0000);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_step;
        t_seq;
        t_abs;
        t_long;
        t_rel;
        t_cond;
        t_idx;
        t_table;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule